// File: doc/BRIEF.md
# Transmit Descriptor Ring Pointer Manager

This block keeps the pointer state of a circular transmit descriptor queue that lives in host memory. It turns that state into byte addresses for fetching descriptors. Software reaches five registers through a plain write/read port:

- the 64-bit ring base, written as a low half and a high half;
- the ring size in bytes;
- the head descriptor index;
- the tail descriptor index.

Software moves tail forward to hand descriptors to hardware. Hardware moves head forward as descriptors are taken downstream.

On the fetch side the block offers a valid/ready stream. While head differs from tail, `fetch_valid` is high and `fetch_addr` carries the byte address of the descriptor at head. That address is the base plus head times 16. A transfer happens on every rising edge where `fetch_valid` and `fetch_ready` are both high. Each transfer moves head to the next slot, and head wraps to slot zero after the last slot.

Back-pressure is expressed by holding `fetch_ready` low. The block then keeps `fetch_valid` and `fetch_addr` unchanged until a transfer or a configuration write occurs. `fetch_ready` has no effect while `fetch_valid` is low. Reading head therefore reports the descriptors already handed downstream.

Top module: `txring_ptr_mgr`

## Requirements
- R1: After a synchronous reset, every register reads zero and `fetch_valid` is low.
- R2: Register select codes are 0 base low half, 1 base high half, 2 ring length, 3 head and 4 tail. Codes 5 to 7 read zero and ignore writes. A write takes effect on the next rising edge, and `cfg_rdata` shows the selected register combinationally.
- R3: Bits 3:0 of the base low half are ignored on write and always read zero, which forces 16-byte alignment.
- R4: In the length register, bits 6:0 always read zero, so the size is a multiple of 128 bytes. Bits 31:20 are ignored and read zero.
- R5: The ring holds length/16 descriptors. `fetch_addr` equals {base high, base low} + head × 16.
- R6: `fetch_valid` is high exactly when the descriptor count is nonzero and head differs from tail. An empty ring therefore raises no request.
- R7: Head increments by one on each rising edge with `fetch_valid` and `fetch_ready` both high. `fetch_ready` without `fetch_valid` leaves head unchanged.
- R8: Head wraps from the last slot (count − 1) to slot zero.
- R9: While `fetch_valid` is high and `fetch_ready` is low, and no configuration write occurs, `fetch_valid` and `fetch_addr` hold their values.
- R10: A write to either base half or to the length register clears head to zero on the next edge. Tail is left unchanged.
- R11: Head and tail writes are stored modulo the descriptor count. When the count is zero, they are stored as zero.
- R12: A software head write in the same cycle as a fetch transfer takes priority over the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code (see R2) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| fetch_valid | output | 1 | Descriptor fetch request pending |
| fetch_ready | input | 1 | Downstream accepts the request |
| fetch_addr | output | 64 | Byte address of the descriptor at head |

## Verification
Register writes and fetch transfers take effect on the rising edge that samples them. Register contents and `fetch_addr` change one edge after the stimulus, and `cfg_rdata` follows `cfg_sel` with no clock. The bench drives every input on the falling edge, so each write or transfer lands on exactly the next rising edge. It samples results 1 ns after a later falling edge, once the combinational read path has settled. Transfer tests count falling edges with `fetch_ready` high, so the expected head equals the starting head plus that count, taken modulo the ring size.

// File: rtl/txring_pkg.sv
package txring_pkg;

  typedef enum logic [2:0] {
    SEL_BASE_LO = 3'd0,
    SEL_BASE_HI = 3'd1,
    SEL_LEN     = 3'd2,
    SEL_HEAD    = 3'd3,
    SEL_TAIL    = 3'd4
  } reg_sel_e;

  localparam int unsigned DESC_SHIFT = 4;  // 16-byte descriptors

endpackage

// File: rtl/txring_regs.sv
module txring_regs
  import txring_pkg::*;
#(
  parameter int unsigned PTR_W     = 16,
  parameter int unsigned LEN_ALIGN = 7,
  parameter int unsigned BASE_ALIGN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic [PTR_W-1:0] head_i,
  output logic [31:0]      cfg_rdata,
  output logic [63:0]      base_o,
  output logic [PTR_W-1:0] count_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             ring_clr_o,
  output logic             head_wr_o,
  output logic [PTR_W-1:0] head_wr_val_o
);

  localparam int unsigned LEN_W = PTR_W + DESC_SHIFT;

  logic [31:0]      base_lo_q;
  logic [31:0]      base_hi_q;
  logic [LEN_W-1:0] len_q;
  logic [PTR_W-1:0] tail_q;
  logic [PTR_W-1:0] wr_ptr_mod;

  assign count_o = len_q[LEN_W-1:DESC_SHIFT];
  assign base_o  = {base_hi_q, base_lo_q};
  assign tail_o  = tail_q;

  // Pointer writes are folded into the current ring size.
  always_comb begin
    if (count_o == '0) wr_ptr_mod = '0;
    else               wr_ptr_mod = cfg_wdata[PTR_W-1:0] % count_o;
  end

  assign ring_clr_o    = cfg_we && (cfg_sel == SEL_BASE_LO || cfg_sel == SEL_BASE_HI ||
                                    cfg_sel == SEL_LEN);
  assign head_wr_o     = cfg_we && (cfg_sel == SEL_HEAD);
  assign head_wr_val_o = wr_ptr_mod;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      len_q     <= '0;
      tail_q    <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_BASE_LO: base_lo_q <= {cfg_wdata[31:BASE_ALIGN], BASE_ALIGN'(0)};
        SEL_BASE_HI: base_hi_q <= cfg_wdata;
        SEL_LEN:     len_q     <= {cfg_wdata[LEN_W-1:LEN_ALIGN], LEN_ALIGN'(0)};
        SEL_TAIL:    tail_q    <= wr_ptr_mod;
        default:     ;
      endcase
    end
  end

  always_comb begin
    case (cfg_sel)
      SEL_BASE_LO: cfg_rdata = base_lo_q;
      SEL_BASE_HI: cfg_rdata = base_hi_q;
      SEL_LEN:     cfg_rdata = 32'(len_q);
      SEL_HEAD:    cfg_rdata = 32'(head_i);
      SEL_TAIL:    cfg_rdata = 32'(tail_q);
      default:     cfg_rdata = '0;
    endcase
  end

  // R3
  base_align_chk: assert property (@(posedge clk) disable iff (rst)
    base_lo_q[BASE_ALIGN-1:0] == '0);

  // R4
  len_align_chk: assert property (@(posedge clk) disable iff (rst)
    len_q[LEN_ALIGN-1:0] == '0);

  // R11
  tail_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == SEL_TAIL && count_o != '0) |=> (tail_q < count_o));

endmodule

// File: rtl/txring_head.sv
module txring_head #(
  parameter int unsigned PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] count_i,
  input  logic [PTR_W-1:0] tail_i,
  input  logic             clr_i,
  input  logic             sw_we_i,
  input  logic [PTR_W-1:0] sw_val_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [PTR_W-1:0] head_o
);

  logic [PTR_W-1:0] head_q;
  logic [PTR_W-1:0] head_next_slot;
  logic             last_slot;

  assign last_slot      = (head_q == count_i - PTR_W'(1));
  assign head_next_slot = last_slot ? '0 : head_q + PTR_W'(1);
  assign valid_o        = (count_i != '0) && (head_q != tail_i);
  assign head_o         = head_q;

  always_ff @(posedge clk) begin
    if (rst)                   head_q <= '0;
    else if (clr_i)            head_q <= '0;
    else if (sw_we_i)          head_q <= sw_val_i;
    else if (valid_o && ready_i) head_q <= head_next_slot;
  end

  // R7
  head_step_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ready_i && !clr_i && !sw_we_i) |=> (head_q != $past(head_q)));

  // R7
  head_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !clr_i && !sw_we_i) |=> $stable(head_q));

  // R8
  head_range_chk: assert property (@(posedge clk) disable iff (rst)
    (count_i != '0 && !clr_i) |=> (head_q < count_i || $changed(count_i)));

endmodule

// File: rtl/txring_addr.sv
module txring_addr #(
  parameter int unsigned PTR_W = 16,
  parameter int unsigned SHIFT = 4
) (
  input  logic [63:0]      base_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [63:0]      addr_o
);

  logic [63:0] offset;

  assign offset = 64'(ptr_i) << SHIFT;
  assign addr_o = base_i + offset;

endmodule

// File: rtl/txring_ptr_mgr.sv
module txring_ptr_mgr
  import txring_pkg::*;
#(
  parameter int unsigned PTR_W     = 16,
  parameter int unsigned LEN_ALIGN = 7,
  parameter int unsigned BASE_ALIGN = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        fetch_valid,
  input  logic        fetch_ready,
  output logic [63:0] fetch_addr
);

  logic [63:0]      base;
  logic [PTR_W-1:0] count;
  logic [PTR_W-1:0] tail;
  logic [PTR_W-1:0] head;
  logic             ring_clr;
  logic             head_wr;
  logic [PTR_W-1:0] head_wr_val;

  txring_regs #(
    .PTR_W(PTR_W), .LEN_ALIGN(LEN_ALIGN), .BASE_ALIGN(BASE_ALIGN)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .head_i(head), .cfg_rdata(cfg_rdata),
    .base_o(base), .count_o(count), .tail_o(tail),
    .ring_clr_o(ring_clr), .head_wr_o(head_wr), .head_wr_val_o(head_wr_val)
  );

  txring_head #(.PTR_W(PTR_W)) u_head (
    .clk(clk), .rst(rst),
    .count_i(count), .tail_i(tail),
    .clr_i(ring_clr), .sw_we_i(head_wr), .sw_val_i(head_wr_val),
    .ready_i(fetch_ready), .valid_o(fetch_valid), .head_o(head)
  );

  txring_addr #(.PTR_W(PTR_W), .SHIFT(DESC_SHIFT)) u_addr (
    .base_i(base), .ptr_i(head), .addr_o(fetch_addr)
  );

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !fetch_ready && !cfg_we) |=> (fetch_valid && $stable(fetch_addr)));

  // R10
  head_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (cfg_sel == SEL_BASE_LO || cfg_sel == SEL_BASE_HI || cfg_sel == SEL_LEN))
    |=> (head == '0));

  // R12
  sw_head_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == SEL_HEAD && count != '0) |=> (head == $past(head_wr_val)));

endmodule

// File: tb/test_txring_ptr_mgr.sv
`timescale 1ns/1ps
module test_txring_ptr_mgr;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        fetch_valid;
  logic        fetch_ready;
  logic [63:0] fetch_addr;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [63:0] BASE = 64'h0000_0001_1000_0000;

  always #2 clk = ~clk;  // 250 MHz

  txring_ptr_mgr i_txring_ptr_mgr (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] data);
    cfg_sel = sel;
    #1;
    data = cfg_rdata;
  endtask

  task automatic accept(input int n);
    @(negedge clk);
    fetch_ready = 1'b1;
    repeat (n) @(negedge clk);
    fetch_ready = 1'b0;
  endtask

  task automatic setup_ring();
    wr(3'd0, BASE[31:0] | 32'h8);
    wr(3'd1, BASE[63:32]);
    wr(3'd2, 32'd128);  // 8 descriptors
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), d);
      check("R1 reg after reset", d, 0);
    end
    check("R1 valid after reset", fetch_valid, 0);
  endtask

  task automatic t_align();
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R3 base low mask", d, 32'hFFFF_FFF0);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R4 length mask", d, 32'h000F_FF80);
    wr(3'd6, 32'h1234_5678);
    rd(3'd6, d); check("R2 unused select reads zero", d, 0);
    rd(3'd0, d); check("R2 unused write ignored", d, 32'hFFFF_FFF0);
  endtask

  task automatic t_fetch();
    logic [31:0] d;
    setup_ring();
    wr(3'd4, 32'd0);
    check("R6 empty ring no request", fetch_valid, 0);
    accept(3);
    rd(3'd3, d); check("R7 ready without valid", d, 0);
    wr(3'd4, 32'd3);
    check("R6 request pending", fetch_valid, 1);
    check("R5 address slot 0", fetch_addr, BASE);
    accept(1);
    rd(3'd3, d); check("R7 head after one transfer", d, 1);
    check("R5 address slot 1", fetch_addr, BASE + 64'd16);
    accept(4);
    rd(3'd3, d); check("R7 head stops at tail", d, 3);
    check("R6 drained ring", fetch_valid, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(3'd3, 32'd5);
    wr(3'd4, 32'd2);
    accept(3);
    rd(3'd3, d); check("R8 head wrapped to zero", d, 0);
    check("R8 address after wrap", fetch_addr, BASE);
    accept(2);
    rd(3'd3, d); check("R8 head after wrap reaches tail", d, 2);
    check("R6 empty after wrap", fetch_valid, 0);
  endtask

  task automatic t_backpressure();
    wr(3'd3, 32'd6);
    wr(3'd4, 32'd1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 valid held", fetch_valid, 1);
      check("R9 address held", fetch_addr, BASE + 64'd96);
    end
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(3'd1, BASE[63:32]);
    rd(3'd3, d); check("R10 head cleared by base write", d, 0);
    rd(3'd4, d); check("R10 tail kept", d, 1);
    accept(1);
    wr(3'd2, 32'd128);
    rd(3'd3, d); check("R10 head cleared by length write", d, 0);
  endtask

  task automatic t_modulo();
    logic [31:0] d;
    wr(3'd4, 32'd11);
    rd(3'd4, d); check("R11 tail modulo", d, 3);
    wr(3'd3, 32'd20);
    rd(3'd3, d); check("R11 head modulo", d, 4);
    wr(3'd2, 32'd0);
    wr(3'd4, 32'd5);
    rd(3'd4, d); check("R11 tail with zero count", d, 0);
    check("R6 zero count no request", fetch_valid, 0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    setup_ring();
    wr(3'd4, 32'd5);
    wr(3'd3, 32'd1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd3; cfg_wdata = 32'd6; fetch_ready = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; fetch_ready = 1'b0;
    rd(3'd3, d); check("R12 software head wins", d, 6);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = 3'd0; cfg_wdata = '0; fetch_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_align();
    t_fetch();
    t_wrap();
    t_backpressure();
    t_clear();
    t_modulo();
    t_priority();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule